// File: doc/BRIEF.md
# Shared HDLC Overhead Arbiter

This block lets two framers share one HDLC engine for their data-link overhead bits. One framer is the primary line framer and the other is a secondary cell-convergence framer. A select request picks the framer whose receive overhead bits and bit-enable reach the engine. That same framer also gets the engine's transmit bit on its overhead output. The framer that is not selected sees a constant one on its transmit overhead output, which is an idle line.

The selected framer may report loss of frame or AIS. While it does, the receive bit fed to the engine is held at one, and the enable keeps following the framer's bit-enable. The engine therefore keeps being clocked through the alarm. The stream of ones it receives makes any half-received packet end in an abort, so a long corrupt packet cannot build up.

A small receive detector is part of the block so that this behaviour can be seen. It finds flags, deletes stuffed zeros, raises an abort pulse and passes payload bits on. Flag bits are stripped from the data by a short delay line.

Top module: `hdlc_ovh_share`

## Requirements
- R1: `sel_active` is 0 (line framer) after reset, and `frame_open` is 0 after reset. While `sel_active` is 0, `eng_rx_bit` and `eng_rx_en` follow `line_rx_bit` and `line_ovh_en`. While `sel_active` is 1, they follow `cell_rx_bit` and `cell_ovh_en`. The bits of the framer that is not selected have no effect.
- R2: The selected framer's transmit overhead output equals `eng_tx_bit`. The other framer's transmit overhead output is 1.
- R3: While the selected framer's LOF or AIS input is high, `eng_rx_bit` is 1 and `eng_rx_en` still follows the selected enable. Alarms on the framer that is not selected have no effect.
- R4: The detector changes state, and emits pulses or data, only after cycles where `eng_rx_en` is 1.
- R5: A flag is a 0, then six 1s, then a 0, in arrival order. The closing 0 is accepted at a clock edge. At that edge `flag_pulse` goes high for one cycle and `frame_open` becomes 1. A flag both ends the current frame and opens the next one.
- R6: While `frame_open` is 1, a seventh consecutive 1 raises `abort_pulse` for one cycle and clears `frame_open`. While hunting for a flag, runs of ones raise no abort.
- R7: Inside an open frame, a 0 that follows five 1s is deleted. Every other payload bit appears on `rx_data` with `rx_valid`, in arrival order. Flag bits never appear on `rx_data`, and no data is emitted while hunting.
- R8: `sel_active` takes the value of `sel_req` at a clock edge only if `frame_open` was 0 before that edge. While a frame is open, `sel_active` holds.
- R9: If the selected framer raises an alarm while a frame is open and enabled cycles continue, the forced ones end that frame with `abort_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_req | input | 1 | Requested owner of the engine: 0 line framer, 1 cell framer |
| line_rx_bit | input | 1 | Line framer receive overhead bit |
| line_ovh_en | input | 1 | Line framer overhead bit enable |
| line_lof | input | 1 | Line framer loss of frame |
| line_ais | input | 1 | Line framer AIS detected |
| cell_rx_bit | input | 1 | Cell framer receive overhead bit |
| cell_ovh_en | input | 1 | Cell framer overhead bit enable |
| cell_lof | input | 1 | Cell framer loss of frame |
| cell_ais | input | 1 | Cell framer AIS detected |
| eng_tx_bit | input | 1 | Transmit overhead bit from the engine |
| line_tx_ovh | output | 1 | Transmit overhead bit to the line framer |
| cell_tx_ovh | output | 1 | Transmit overhead bit to the cell framer |
| sel_active | output | 1 | Framer that currently owns the engine |
| eng_rx_bit | output | 1 | Receive bit presented to the engine |
| eng_rx_en | output | 1 | Receive bit enable presented to the engine |
| frame_open | output | 1 | Detector is inside a frame |
| flag_pulse | output | 1 | One-cycle pulse when a flag is recognised |
| abort_pulse | output | 1 | One-cycle pulse when a frame is aborted |
| rx_valid | output | 1 | `rx_data` holds a payload bit |
| rx_data | output | 1 | Destuffed payload bit |

## Verification
The assertions check the following on every cycle:
- the idle side's transmit output stays at one;
- an alarm on the owning framer forces ones and the receive enable still follows that framer;
- the detector is frozen on cycles without an enable;
- an abort is a single cycle and always closes the frame;
- data never appears outside a frame;
- the owner never changes while a frame is open.

Some behaviour only the bench scenarios can show:
- payload bits come out in order, with stuffed zeros deleted and flags stripped;
- a flag both closes one frame and opens the next;
- a select request made during a frame waits until an abort closes it;
- an alarm in the middle of a frame ends that frame through forced ones.

// File: rtl/hdlc_share_pkg.sv
package hdlc_share_pkg;
  typedef enum logic {
    SRC_LINE = 1'b0,
    SRC_CELL = 1'b1
  } src_t;

  localparam int N_SRC = 2;
endpackage

// File: rtl/ovh_src_select.sv
module ovh_src_select
  import hdlc_share_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_t sel_req,
  input  logic frame_open,
  output src_t sel_q
);
  src_t sel_d;

  always_comb begin
    sel_d = sel_q;
    if (!frame_open) sel_d = sel_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SRC_LINE;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/ovh_rx_steer.sv
module ovh_rx_steer #(
  parameter int NSRC  = 2,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [SELW-1:0] sel,
  input  logic [NSRC-1:0] rx_bit,
  input  logic [NSRC-1:0] rx_en,
  input  logic [NSRC-1:0] alarm,
  output logic            eng_bit,
  output logic            eng_en
);
  always_comb begin
    eng_en  = rx_en[sel];
    eng_bit = alarm[sel] ? 1'b1 : rx_bit[sel];
  end
endmodule

// File: rtl/ovh_tx_fanout.sv
module ovh_tx_fanout #(
  parameter int NSRC  = 2,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [SELW-1:0] sel,
  input  logic            eng_tx,
  output logic [NSRC-1:0] tx_ovh
);
  for (genvar g = 0; g < NSRC; g++) begin : g_side
    assign tx_ovh[g] = (sel == SELW'(g)) ? eng_tx : 1'b1;
  end
endmodule

// File: rtl/hdlc_rx_detect.sv
module hdlc_rx_detect #(
  parameter int FLAG_ONES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic open_q,
  output logic flag_q,
  output logic abort_q,
  output logic vld_q,
  output logic dbit_q
);
  localparam int STUFF_ONES = FLAG_ONES - 1;
  localparam int DEPTH      = FLAG_ONES + 1;
  localparam int CNT_W      = $clog2(FLAG_ONES + 2);
  localparam int FILL_W     = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0]  L_FLAG  = CNT_W'(FLAG_ONES);
  localparam logic [CNT_W-1:0]  L_STUFF = CNT_W'(STUFF_ONES);
  localparam logic [CNT_W-1:0]  L_SAT   = CNT_W'(FLAG_ONES + 1);
  localparam logic [FILL_W-1:0] L_FULL  = FILL_W'(DEPTH);

  logic [CNT_W-1:0]  ones_q, ones_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [DEPTH-1:0]  pipe_q, pipe_d;
  logic              seen0_q, seen0_d, open_d;
  logic              flag_d, abort_d, vld_d, dbit_d, push;

  always_comb begin
    ones_d  = ones_q;
    fill_d  = fill_q;
    pipe_d  = pipe_q;
    seen0_d = seen0_q;
    open_d  = open_q;
    flag_d  = 1'b0;
    abort_d = 1'b0;
    vld_d   = 1'b0;
    dbit_d  = 1'b0;
    push    = 1'b0;
    if (bit_en) begin
      if (bit_in) begin
        if (ones_q != L_SAT) ones_d = ones_q + 1'b1;
        if (open_q && ones_q == L_FLAG) begin
          abort_d = 1'b1;
          open_d  = 1'b0;
          fill_d  = '0;
        end else if (open_q) begin
          push = 1'b1;
        end
      end else begin
        ones_d  = '0;
        seen0_d = 1'b1;
        if (seen0_q && ones_q == L_FLAG) begin
          flag_d = 1'b1;
          open_d = 1'b1;
          fill_d = '0;
        end else if (open_q && ones_q != L_STUFF) begin
          push = 1'b1;
        end
      end
      if (push) begin
        pipe_d = {pipe_q[DEPTH-2:0], bit_in};
        if (fill_q == L_FULL) begin
          vld_d  = 1'b1;
          dbit_d = pipe_q[DEPTH-1];
        end else begin
          fill_d = fill_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q  <= '0;
      fill_q  <= '0;
      pipe_q  <= '0;
      seen0_q <= 1'b0;
      open_q  <= 1'b0;
      flag_q  <= 1'b0;
      abort_q <= 1'b0;
      vld_q   <= 1'b0;
      dbit_q  <= 1'b0;
    end else begin
      ones_q  <= ones_d;
      fill_q  <= fill_d;
      pipe_q  <= pipe_d;
      seen0_q <= seen0_d;
      open_q  <= open_d;
      flag_q  <= flag_d;
      abort_q <= abort_d;
      vld_q   <= vld_d;
      dbit_q  <= dbit_d;
    end
  end
endmodule

// File: rtl/hdlc_ovh_share.sv
module hdlc_ovh_share
  import hdlc_share_pkg::*;
#(
  parameter int FLAG_ONES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_req,
  input  logic line_rx_bit,
  input  logic line_ovh_en,
  input  logic line_lof,
  input  logic line_ais,
  input  logic cell_rx_bit,
  input  logic cell_ovh_en,
  input  logic cell_lof,
  input  logic cell_ais,
  input  logic eng_tx_bit,
  output logic line_tx_ovh,
  output logic cell_tx_ovh,
  output logic sel_active,
  output logic eng_rx_bit,
  output logic eng_rx_en,
  output logic frame_open,
  output logic flag_pulse,
  output logic abort_pulse,
  output logic rx_valid,
  output logic rx_data
);
  src_t             sel_q;
  logic [N_SRC-1:0] rx_bits, rx_ens, alarms, tx_vec;

  assign rx_bits     = {cell_rx_bit, line_rx_bit};
  assign rx_ens      = {cell_ovh_en, line_ovh_en};
  assign alarms      = {cell_lof | cell_ais, line_lof | line_ais};
  assign line_tx_ovh = tx_vec[SRC_LINE];
  assign cell_tx_ovh = tx_vec[SRC_CELL];
  assign sel_active  = sel_q;

  ovh_src_select u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_req    (src_t'(sel_req)),
    .frame_open (frame_open),
    .sel_q      (sel_q)
  );

  ovh_rx_steer #(.NSRC(N_SRC)) u_steer (
    .sel     (sel_q),
    .rx_bit  (rx_bits),
    .rx_en   (rx_ens),
    .alarm   (alarms),
    .eng_bit (eng_rx_bit),
    .eng_en  (eng_rx_en)
  );

  ovh_tx_fanout #(.NSRC(N_SRC)) u_tx (
    .sel    (sel_q),
    .eng_tx (eng_tx_bit),
    .tx_ovh (tx_vec)
  );

  hdlc_rx_detect #(.FLAG_ONES(FLAG_ONES)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (eng_rx_en),
    .bit_in  (eng_rx_bit),
    .open_q  (frame_open),
    .flag_q  (flag_pulse),
    .abort_q (abort_pulse),
    .vld_q   (rx_valid),
    .dbit_q  (rx_data)
  );
endmodule

// File: rtl/hdlc_ovh_share_chk.sv
module hdlc_ovh_share_chk (
  input logic clk,
  input logic rst_n,
  input logic line_ovh_en,
  input logic cell_ovh_en,
  input logic line_lof,
  input logic line_ais,
  input logic cell_lof,
  input logic cell_ais,
  input logic line_tx_ovh,
  input logic cell_tx_ovh,
  input logic sel_active,
  input logic eng_rx_bit,
  input logic eng_rx_en,
  input logic frame_open,
  input logic flag_pulse,
  input logic abort_pulse,
  input logic rx_valid
);
  logic alarm_owned;
  assign alarm_owned = sel_active ? (cell_lof | cell_ais) : (line_lof | line_ais);

  a_r2_line_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
    sel_active |-> line_tx_ovh);
  a_r2_cell_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |-> cell_tx_ovh);
  a_r3_force_ones: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_owned |-> eng_rx_bit);
  a_r3_clock_kept: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_owned |-> (eng_rx_en == (sel_active ? cell_ovh_en : line_ovh_en)));
  a_r4_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_rx_en |=> (!flag_pulse && !abort_pulse && !rx_valid && $stable(frame_open)));
  a_r5_flag_opens: assert property (@(posedge clk) disable iff (!rst_n)
    flag_pulse |-> frame_open);
  a_r6_abort_closes: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !frame_open);
  a_r6_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);
  a_r7_data_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> frame_open);
  a_r8_owner_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    frame_open |=> $stable(sel_active));
endmodule

bind hdlc_ovh_share hdlc_ovh_share_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_ovh_en (line_ovh_en),
  .cell_ovh_en (cell_ovh_en),
  .line_lof    (line_lof),
  .line_ais    (line_ais),
  .cell_lof    (cell_lof),
  .cell_ais    (cell_ais),
  .line_tx_ovh (line_tx_ovh),
  .cell_tx_ovh (cell_tx_ovh),
  .sel_active  (sel_active),
  .eng_rx_bit  (eng_rx_bit),
  .eng_rx_en   (eng_rx_en),
  .frame_open  (frame_open),
  .flag_pulse  (flag_pulse),
  .abort_pulse (abort_pulse),
  .rx_valid    (rx_valid)
);

// File: tb/sim_hdlc_ovh_share.sv
`timescale 1ns/1ps
module sim_hdlc_ovh_share;
  logic clk, rst_n, sel_req;
  logic line_rx_bit, line_ovh_en, line_lof, line_ais;
  logic cell_rx_bit, cell_ovh_en, cell_lof, cell_ais, eng_tx_bit;
  logic line_tx_ovh, cell_tx_ovh, sel_active, eng_rx_bit, eng_rx_en;
  logic frame_open, flag_pulse, abort_pulse, rx_valid, rx_data;

  int checks = 0;
  int errors = 0;
  int flags_seen = 0;
  int aborts_seen = 0;
  int ones_run = 0;
  bit ignore_data = 1'b0;
  bit done = 1'b0;
  bit expq[$];

  hdlc_ovh_share u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic drive(input bit src, input bit b);
    @(posedge clk); #1;
    if (src) begin cell_rx_bit = b; cell_ovh_en = 1'b1; line_ovh_en = 1'b0; end
    else     begin line_rx_bit = b; line_ovh_en = 1'b1; cell_ovh_en = 1'b0; end
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    line_ovh_en = 1'b0;
    cell_ovh_en = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_flag(input bit src);
    drive(src, 1'b0);
    repeat (6) drive(src, 1'b1);
    drive(src, 1'b0);
    ones_run = 0;
  endtask

  task automatic send_pbit(input bit src, input bit b);
    if (!ignore_data) expq.push_back(b);
    drive(src, b);
    ones_run = b ? ones_run + 1 : 0;
    if (ones_run == 5) begin
      drive(src, 1'b0);
      ones_run = 0;
    end
  endtask

  task automatic send_byte(input bit src, input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_pbit(src, v[i]);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (flag_pulse) flags_seen++;
      if (abort_pulse) aborts_seen++;
      if (rx_valid && !ignore_data) begin
        if (expq.size() == 0) chk(1'b0, "R7 unexpected payload bit", rx_data, -1);
        else chk(rx_data == expq.pop_front(), "R7 payload bit order", rx_data, -2);
      end
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int f0, a0;
    rst_n = 1'b0; sel_req = 1'b0;
    line_rx_bit = 1'b1; line_ovh_en = 1'b0; line_lof = 1'b0; line_ais = 1'b0;
    cell_rx_bit = 1'b1; cell_ovh_en = 1'b0; cell_lof = 1'b0; cell_ais = 1'b0;
    eng_tx_bit = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk(sel_active == 1'b0, "R1 reset owner", sel_active, 0);
    chk(frame_open == 1'b0, "R1 reset frame_open", frame_open, 0);

    // R2 transmit routing, line owner
    eng_tx_bit = 1'b0; #1;
    chk(line_tx_ovh == 1'b0, "R2 owner tx follows engine", line_tx_ovh, 0);
    chk(cell_tx_ovh == 1'b1, "R2 idle side ones", cell_tx_ovh, 1);
    eng_tx_bit = 1'b1; #1;

    // R1 receive routing; R3 idle-side alarm ignored
    line_rx_bit = 1'b0; line_ovh_en = 1'b1; cell_rx_bit = 1'b1; cell_ovh_en = 1'b0;
    cell_ais = 1'b1; #1;
    chk(eng_rx_bit == 1'b0, "R1 line bit routed", eng_rx_bit, 0);
    chk(eng_rx_en == 1'b1, "R1 line enable routed", eng_rx_en, 1);
    chk(eng_rx_bit == 1'b0, "R3 unselected alarm ignored", eng_rx_bit, 0);
    cell_ais = 1'b0;
    idle(2);

    // R5 / R7 framed payload with stuffing
    f0 = flags_seen;
    send_flag(0);
    send_byte(0, 8'hA5);
    send_byte(0, 8'hFF);
    send_byte(0, 8'h3E);
    send_flag(0);
    idle(3);
    chk(flags_seen - f0 == 2, "R5 flags counted", flags_seen - f0, 2);
    chk(frame_open == 1'b1, "R5 frame open after flag", frame_open, 1);
    chk(expq.size() == 0, "R7 all payload bits delivered", expq.size(), 0);

    // R4 disabled cycles are ignored
    a0 = aborts_seen;
    line_rx_bit = 1'b1; cell_rx_bit = 1'b1; cell_ovh_en = 1'b1;
    repeat (20) @(posedge clk);
    #1 cell_ovh_en = 1'b0;
    idle(2);
    chk(frame_open == 1'b1, "R4 frame kept with enable low", frame_open, 1);
    chk(aborts_seen == a0, "R4 no abort with enable low", aborts_seen - a0, 0);

    // R8 select request held while frame open
    sel_req = 1'b1;
    idle(3);
    chk(sel_active == 1'b0, "R8 owner held during frame", sel_active, 0);

    // R6 abort on seventh one
    ignore_data = 1'b1;
    repeat (7) drive(0, 1'b1);
    idle(2);
    chk(aborts_seen - a0 == 1, "R6 abort pulse", aborts_seen - a0, 1);
    chk(frame_open == 1'b0, "R6 frame closed by abort", frame_open, 0);
    chk(sel_active == 1'b1, "R8 owner switches once idle", sel_active, 1);

    // R6 hunting ones raise no abort (cell now owner, R1)
    a0 = aborts_seen;
    repeat (12) drive(1, 1'b1);
    idle(2);
    chk(aborts_seen == a0, "R6 no abort while hunting", aborts_seen - a0, 0);

    // R2 transmit routing, cell owner
    eng_tx_bit = 1'b0; #1;
    chk(cell_tx_ovh == 1'b0, "R2 cell owner tx follows engine", cell_tx_ovh, 0);
    chk(line_tx_ovh == 1'b1, "R2 line idle side ones", line_tx_ovh, 1);
    eng_tx_bit = 1'b1;

    // R3 / R9 alarm forcing during open frame
    send_flag(1);
    send_byte(1, 8'h12);
    idle(1);
    chk(frame_open == 1'b1, "R9 frame open before alarm", frame_open, 1);
    a0 = aborts_seen;
    cell_lof = 1'b1; cell_rx_bit = 1'b0; cell_ovh_en = 1'b1; #1;
    chk(eng_rx_bit == 1'b1, "R3 LOF forces ones", eng_rx_bit, 1);
    chk(eng_rx_en == 1'b1, "R3 enable kept under alarm", eng_rx_en, 1);
    cell_ovh_en = 1'b0;
    repeat (8) drive(1, 1'b0);
    idle(2);
    chk(aborts_seen - a0 == 1, "R9 forced ones abort", aborts_seen - a0, 1);
    chk(frame_open == 1'b0, "R9 frame closed", frame_open, 0);
    cell_lof = 1'b0; cell_ais = 1'b1; cell_rx_bit = 1'b0; #1;
    chk(eng_rx_bit == 1'b1, "R3 AIS forces ones", eng_rx_bit, 1);
    cell_ais = 1'b0;
    idle(1);

    // R7 / R1 clean frame on cell owner
    expq.delete();
    ignore_data = 1'b0;
    f0 = flags_seen;
    send_flag(1);
    send_byte(1, 8'hFF);
    send_byte(1, 8'h7C);
    send_flag(1);
    idle(3);
    chk(flags_seen - f0 == 2, "R1 cell frame flags", flags_seen - f0, 2);
    chk(expq.size() == 0, "R7 cell payload delivered", expq.size(), 0);

    finish_run();
  end
endmodule